// File: doc/BRIEF.md
# Instruction Count Trigger

This block is a debug trigger that counts down while the hart retires instructions or takes exceptions in chosen privilege modes. When the count runs out it raises one request for the action it holds: a breakpoint exception, entry into debug mode, or the start of tracing. Debug logic uses it to stop a program after a set number of steps. A single register write port loads the count, the per-mode enables, the action code and a protect bit. A packed read-back word shows the same fields.

While the protect bit is set, only writes made in debug mode take effect. Only debug mode can set the protect bit. The enter-debug action needs the protect bit. Counting is suspended while the hart is in debug mode.

Top module: `icnt_trigger`

## Requirements
- R1: After reset the read-back word is zero and all three request outputs are low.
- R2: Register word layout: count in bits 23:10, mode enables M at bit 9, H at bit 8, S at bit 7, U at bit 6, action code in bits 5:0, protect bit at bit XLEN-5 (27 for XLEN=32), all other bits zero. An accepted write is visible on the read-back in the next cycle. Privilege encoding is U=0, S=1, H=2, M=3.
- R3: A cycle with the retire strobe high, outside debug mode, with the current privilege's enable set and a nonzero count, lowers the count by exactly one. When the enable for the current privilege is clear, the count does not change.
- R4: The exception-taken strobe counts in the same way as the retire strobe. A cycle with both strobes high lowers the count by one only.
- R5: While the debug-mode flag is high, strobes do not change the count.
- R6: A counting event that takes the count from 1 to 0 raises exactly one request, for exactly the next cycle. Action code 0 raises the breakpoint request, 1 raises the enter-debug request, and 2 raises the trace request. Any other code raises none.
- R7: A count of 0 stays at 0 under strobes and raises no request.
- R8: An action code of 1 written while the resulting protect bit is 0 is stored as code 0.
- R9: While the protect bit is 1, a write made outside debug mode changes nothing.
- R10: A write made outside debug mode leaves the protect bit unchanged. A write made in debug mode sets the protect bit to the written value.
- R11: When an accepted write and a counting event fall in the same cycle, the written count is stored and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | One instruction completed this cycle |
| exc_i | input | 1 | An exception was taken this cycle |
| priv_i | input | 2 | Current privilege (U=0, S=1, H=2, M=3) |
| dbg_mode_i | input | 1 | Hart is in debug mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | XLEN | Register write data |
| rd_data_o | output | XLEN | Packed register read-back |
| brk_req_o | output | 1 | Breakpoint exception request |
| dbg_req_o | output | 1 | Enter debug mode request |
| trace_req_o | output | 1 | Start tracing request |

## Verification
The countdown is tried with several strobe patterns: retire only, exception only, both strobes together, strobes in a disabled privilege, and strobes in debug mode. These patterns separate correct gating from a counter that miscounts, double-steps, or ignores the enables. Firing is tried with action codes 0, 1, 2 and 5, which shows whether each code reaches the right request and whether unused codes stay silent. Writes are tried inside and outside debug mode, with the protect bit both set and clear, and one write falls on a counting cycle. Together these expose leaks in the write protection and the wrong priority between a write and a count.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
   typedef enum logic [1:0] {
      PRIV_U = 2'd0,
      PRIV_S = 2'd1,
      PRIV_H = 2'd2,
      PRIV_M = 2'd3
   } priv_e;

   localparam int ACT_W    = 6;
   localparam int EN_LSB   = 6;
   localparam int CNT_LSB  = 10;
   localparam int N_PRIV   = 4;

   localparam logic [ACT_W-1:0] ACT_BRK   = 6'd0;
   localparam logic [ACT_W-1:0] ACT_DBG   = 6'd1;
   localparam logic [ACT_W-1:0] ACT_TRACE = 6'd2;

   typedef struct packed {
      logic brk;
      logic dbg;
      logic trace;
   } req_t;
endpackage

// File: rtl/icnt_cfg_reg.sv
module icnt_cfg_reg
   import icnt_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int CNT_W = 14
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    wr_en_i,
   input  logic [XLEN-1:0]         wr_data_i,
   input  logic                    dbg_mode_i,
   output logic                    load_o,
   output logic [CNT_W-1:0]        load_cnt_o,
   output logic [N_PRIV-1:0]       en_o,
   output logic [ACT_W-1:0]        act_o,
   output logic                    hmode_o
);
   localparam int HMODE_BIT = XLEN - 5;

   logic                hmode_q;
   logic [N_PRIV-1:0]   en_q;
   logic [ACT_W-1:0]    act_q;
   logic                wr_ok;
   logic                hmode_nx;
   logic [ACT_W-1:0]    act_nx;
   logic                unused_wr_parity;

   assign unused_wr_parity = ^wr_data_i;

   assign wr_ok    = wr_en_i & (~hmode_q | dbg_mode_i);
   assign hmode_nx = dbg_mode_i ? wr_data_i[HMODE_BIT] : hmode_q;

   always_comb begin
      act_nx = wr_data_i[ACT_W-1:0];
      if (act_nx == ACT_DBG && !hmode_nx) act_nx = ACT_BRK;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hmode_q <= 1'b0;
         en_q    <= '0;
         act_q   <= '0;
      end else if (wr_ok) begin
         hmode_q <= hmode_nx;
         en_q    <= wr_data_i[EN_LSB +: N_PRIV];
         act_q   <= act_nx;
      end
   end

   assign load_o     = wr_ok;
   assign load_cnt_o = wr_data_i[CNT_LSB +: CNT_W];
   assign en_o       = en_q;
   assign act_o      = act_q;
   assign hmode_o    = hmode_q;

   assert_locked_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && hmode_q && !dbg_mode_i) |=> ($stable(act_q) && $stable(en_q) && $stable(hmode_q)));

   assert_dbg_act_needs_hmode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q == ACT_DBG) |-> hmode_q);

   assert_hmode_set_in_dbg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hmode_q) |-> $past(dbg_mode_i));
endmodule

// File: rtl/icnt_counter.sv
module icnt_counter #(
   parameter int CNT_W = 14
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             fire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             nonzero;

   assign nonzero = |cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (load_i)            cnt_q <= load_val_i;
      else if (step_i && nonzero) cnt_q <= cnt_q - CNT_W'(1);
   end

   assign fire_o = step_i && !load_i && (cnt_q == CNT_W'(1));
   assign cnt_o  = cnt_q;

   assert_zero_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

   assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i && !load_i) |=> $stable(cnt_q));

   assert_load_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> !fire_o);
endmodule

// File: rtl/icnt_action.sv
module icnt_action
   import icnt_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fire_i,
   input  logic [ACT_W-1:0] act_i,
   output req_t             req_o
);
   req_t dec;

   always_comb begin
      dec = '0;
      if (fire_i) begin
         dec.brk   = (act_i == ACT_BRK);
         dec.dbg   = (act_i == ACT_DBG);
         dec.trace = (act_i == ACT_TRACE);
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         req_t req_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) req_q <= '0;
            else         req_q <= dec;
         end
         assign req_o = req_q;
      end else begin : g_comb
         assign req_o = dec;
      end
   endgenerate

   assert_one_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(req_o));
endmodule

// File: rtl/icnt_trigger.sv
module icnt_trigger
   import icnt_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CNT_W   = 14,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            retire_i,
   input  logic            exc_i,
   input  logic [1:0]      priv_i,
   input  logic            dbg_mode_i,
   input  logic            wr_en_i,
   input  logic [XLEN-1:0] wr_data_i,
   output logic [XLEN-1:0] rd_data_o,
   output logic            brk_req_o,
   output logic            dbg_req_o,
   output logic            trace_req_o
);
   localparam int HMODE_BIT = XLEN - 5;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("icnt_trigger: XLEN must be 32 or 64");
      end
      if (CNT_LSB + CNT_W > HMODE_BIT) begin : g_bad_cnt
         $error("icnt_trigger: count field overlaps protect bit");
      end
   endgenerate

   logic              load;
   logic [CNT_W-1:0]  load_cnt;
   logic [N_PRIV-1:0] en;
   logic [ACT_W-1:0]  act;
   logic              hmode;
   logic [CNT_W-1:0]  cnt;
   logic              step;
   logic              fire;
   req_t              req;

   icnt_cfg_reg #(.XLEN(XLEN), .CNT_W(CNT_W)) u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_data_i  (wr_data_i),
      .dbg_mode_i (dbg_mode_i),
      .load_o     (load),
      .load_cnt_o (load_cnt),
      .en_o       (en),
      .act_o      (act),
      .hmode_o    (hmode)
   );

   assign step = (retire_i | exc_i) & en[priv_i] & ~dbg_mode_i;

   icnt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .load_val_i (load_cnt),
      .step_i     (step),
      .cnt_o      (cnt),
      .fire_o     (fire)
   );

   icnt_action #(.REG_OUT(REG_OUT)) u_act (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (fire),
      .act_i  (act),
      .req_o  (req)
   );

   always_comb begin
      rd_data_o                       = '0;
      rd_data_o[HMODE_BIT]            = hmode;
      rd_data_o[CNT_LSB +: CNT_W]     = cnt;
      rd_data_o[EN_LSB +: N_PRIV]     = en;
      rd_data_o[ACT_W-1:0]            = act;
   end

   assign brk_req_o   = req.brk;
   assign dbg_req_o   = req.dbg;
   assign trace_req_o = req.trace;

   assert_dbg_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dbg_mode_i && !load) |=> $stable(cnt));

   assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (brk_req_o || dbg_req_o || trace_req_o) |=> !(brk_req_o || dbg_req_o || trace_req_o));
endmodule

// File: tb/icnt_trigger_tb.sv
module icnt_trigger_tb;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            retire = 1'b0, exc = 1'b0, dbg = 1'b0, wr = 1'b0;
   logic [1:0]      priv = 2'd0;
   logic [XLEN-1:0] wdata = '0;
   logic [XLEN-1:0] rdata;
   logic            brk_o, dbgreq_o, trace_o;

   int checks = 0;
   int fails  = 0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   logic        m_h;
   logic [13:0] m_cnt;
   logic [3:0]  m_en;
   logic [5:0]  m_act;

   always #(CLK_PERIOD/2) clk = ~clk;

   icnt_trigger u_dut (
      .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .exc_i(exc),
      .priv_i(priv), .dbg_mode_i(dbg), .wr_en_i(wr), .wr_data_i(wdata),
      .rd_data_o(rdata), .brk_req_o(brk_o), .dbg_req_o(dbgreq_o), .trace_req_o(trace_o)
   );

   function automatic logic [XLEN-1:0] mk(logic h, logic [13:0] c, logic [3:0] e, logic [5:0] a);
      logic [XLEN-1:0] w = '0;
      w[27] = h; w[23:10] = c; w[9:6] = e; w[5:0] = a;
      return w;
   endfunction

   // monitor: pops expected request vectors and compares
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [2:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ({brk_o, dbgreq_o, trace_o} !== e) begin
            fails++;
            $display("FAIL %s req act=%b exp=%b", t, {brk_o, dbgreq_o, trace_o}, e);
         end
      end
   end

   task automatic step(input logic r, input logic x, input logic [1:0] p, input logic d,
                       input logic w, input logic [XLEN-1:0] dat, input string tag);
      logic [2:0] exp;
      logic       ev, wok, nh;
      logic [5:0] na;
      @(negedge clk);
      retire = r; exc = x; priv = p; dbg = d; wr = w; wdata = dat;
      @(posedge clk);
      #1;
      exp = 3'b000;
      wok = w && (!m_h || d);
      ev  = (r || x) && m_en[p] && !d;
      if (wok) begin
         nh = d ? dat[27] : m_h;
         na = dat[5:0];
         if (na == 6'd1 && !nh) na = 6'd0;
         m_h = nh; m_cnt = dat[23:10]; m_en = dat[9:6]; m_act = na;
      end else if (ev && m_cnt != 0) begin
         if (m_cnt == 14'd1) begin
            if (m_act == 6'd0) exp = 3'b100;
            else if (m_act == 6'd1) exp = 3'b010;
            else if (m_act == 6'd2) exp = 3'b001;
         end
         m_cnt = m_cnt - 14'd1;
      end
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic chk_rd(input string tag);
      logic [XLEN-1:0] e;
      e = mk(m_h, m_cnt, m_en, m_act);
      checks++;
      if (rdata !== e) begin
         fails++;
         $display("FAIL %s rd act=%h exp=%h", tag, rdata, e);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      m_h = 0; m_cnt = 0; m_en = 0; m_act = 0;
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if ({brk_o, dbgreq_o, trace_o} !== 3'b000) begin
         fails++; $display("FAIL R1 req act=%b exp=000", {brk_o, dbgreq_o, trace_o});
      end
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk_rd("R1");

      // R2: layout; count 3, M enabled, action 0 (non-debug write, unlocked)
      step(0,0,2'd3,0,1, mk(0,14'd3,4'b1000,6'd0), "R2"); chk_rd("R2");
      step(1,0,2'd3,0,0, '0, "R3"); chk_rd("R3");        // 3 -> 2
      step(1,0,2'd0,0,0, '0, "R3"); chk_rd("R3");        // U disabled, stays 2
      step(1,1,2'd3,0,0, '0, "R4"); chk_rd("R4");        // both strobes, 2 -> 1
      step(1,1,2'd3,1,0, '0, "R5"); chk_rd("R5");        // debug mode, stays 1
      step(0,1,2'd3,0,0, '0, "R6"); chk_rd("R6");        // exception 1 -> 0, breakpoint
      step(0,0,2'd3,0,0, '0, "R6");
      step(1,1,2'd3,0,0, '0, "R7"); chk_rd("R7");        // zero stays zero
      step(0,0,2'd3,0,0, '0, "R7");

      // R8: action 1 without protect becomes 0
      step(0,0,2'd1,0,1, mk(0,14'd1,4'b0010,6'd1), "R8"); chk_rd("R8");
      step(1,0,2'd1,0,0, '0, "R8");                       // fires breakpoint
      step(0,0,2'd1,0,0, '0, "R8");

      // R10: non-debug write cannot set protect bit
      step(0,0,2'd1,0,1, mk(1,14'd9,4'b0010,6'd1), "R10"); chk_rd("R10");
      // R10: debug write sets it; enter-debug action, U enabled, count 2
      step(0,0,2'd0,1,1, mk(1,14'd2,4'b0001,6'd1), "R10"); chk_rd("R10");
      step(1,0,2'd0,0,0, '0, "R6");
      step(1,0,2'd0,0,0, '0, "R6");                       // fires enter-debug
      step(0,0,2'd0,0,0, '0, "R6");
      // R9: locked, non-debug write ignored
      step(0,0,2'd0,0,1, mk(0,14'd7,4'b1111,6'd2), "R9"); chk_rd("R9");

      // R11: unlock from debug, trace action, S enabled, count 1
      step(0,0,2'd1,1,1, mk(0,14'd1,4'b0010,6'd2), "R10"); chk_rd("R10");
      step(1,0,2'd1,0,1, mk(0,14'd4,4'b0010,6'd2), "R11"); chk_rd("R11");
      step(0,0,2'd1,0,0, '0, "R11");
      for (int i = 0; i < 3; i++) step(1,0,2'd1,0,0, '0, "R3");
      chk_rd("R3");
      step(0,1,2'd1,0,0, '0, "R6");                       // fires trace
      step(0,0,2'd1,0,0, '0, "R6");

      // R6: unused action code raises nothing
      step(0,0,2'd2,0,1, mk(0,14'd1,4'b0100,6'd5), "R6"); chk_rd("R6");
      step(1,0,2'd2,0,0, '0, "R6");
      step(0,0,2'd2,0,0, '0, "R6"); chk_rd("R6");

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule